// File: doc/BRIEF.md
# Two-Wire Serial Byte-Memory Slave

This block is the bus-facing half of a small byte-addressed non-volatile store on a two-wire serial bus (I2C). It watches already synchronized and filtered clock and data lines, answers only to one fixed 7-bit device address and keeps an internal word pointer. That pointer is loaded by the first byte after a write-type address. The block supports single-byte and multi-byte page writes, reads from the current pointer, reads from a chosen location through a repeated start, and streaming reads. It pulls the data line low only through an open-drain enable.

The storage array and the page staging buffer live in a companion block. Each accepted data byte goes to the companion as a load, with its target location and a flag that marks the first byte of a session. A stop that closes a write session raises a one-cycle commit request. The slave then counts as busy until the companion returns a done pulse. While busy, the slave refuses its own address, so a master can poll until the store is ready. Read data comes back combinationally from the companion at the location the slave presents.

Top module: `serial_mem_slave`

## Requirements
- R1: After reset the data-line enable is low, no load or commit is issued, and the internal word pointer presented on `rd_addr` is 0.
- R2: An address byte whose upper seven bits equal 1010000 (LSB 1 = read, 0 = write) is acknowledged by holding SDA low during the ninth clock. Any other address gets no acknowledge, and the slave ignores all further bytes until the next start.
- R3: In a write session, the byte after the address is the word pointer. Each following data byte is acknowledged and loaded at the pointer. Then the low 4 bits of the pointer (the offset in a 16-byte page) increment and wrap within the page, so a later byte may replace an earlier one.
- R4: A stop after at least one loaded data byte raises a single commit request. Until the companion's done pulse, the slave does not acknowledge its own address and issues no loads.
- R5: Write protect is sampled at the SCL falling edge that ends the word-pointer acknowledge. If it is high, the first data byte and all later bytes of that session get no acknowledge, and nothing is loaded or committed.
- R6: A read-type address makes the slave send the byte at the current pointer, MSB first. After a completed write session, the pointer holds the location that follows the last loaded byte within its page.
- R7: A write-type address plus a word pointer, followed by a repeated start and a read-type address, reads from that word pointer.
- R8: During a read, a master acknowledge makes the slave send the next byte. The pointer increments across the whole array and wraps from 255 to 0. A master no-acknowledge ends the transfer.
- R9: A start in the middle of a write session discards every byte loaded in that session, with no commit. A stop in the middle of a byte drops only the partial byte and commits the complete ones.
- R10: The slave changes its data output only on SCL falling edges, so the data-line enable never rises while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Synchronized, filtered serial clock |
| sda_i | input | 1 | Synchronized, filtered serial data (bus level) |
| wp_i | input | 1 | Write protect, high blocks writes |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| ld_valid | output | 1 | One-cycle pulse: load a data byte into the staging buffer |
| ld_first | output | 1 | Marks the first load of a session (older staged bytes are dropped) |
| ld_addr | output | 8 | Target location of the loaded byte |
| ld_data | output | 8 | Loaded byte |
| commit_req | output | 1 | One-cycle pulse: write staged bytes to the array |
| commit_done | input | 1 | One-cycle pulse from the companion: commit finished |
| rd_addr | output | 8 | Current word pointer |
| rd_data | input | 8 | Array byte at `rd_addr` |

## Verification
The hardest conditions to reach are bus conditions that arrive in the middle of a byte: a repeated start after a few bits of a data byte, and a stop after complete bytes plus a partial one. The stimulus gets there with bit-level tasks that shift out only part of a byte before the condition is issued. Busy-time refusal is reached by polling at once after each write stop, against a companion model whose commit takes longer than one address byte. A mix of seeded random writes and reads then runs pointer and page wrapping against a reference image of the array.

// File: rtl/sms_pkg.sv
// Shared definitions for the serial byte-memory slave.
// Assumes an 8-bit word pointer at most (one pointer byte on the bus).
package sms_pkg;

    localparam logic [6:0] SMS_DEV_ADDR = 7'b1010000;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_WADDR,
        ST_WADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RD,
        ST_RD_ACK,
        ST_SKIP
    } sms_state_e;

endpackage

// File: rtl/sms_bus_events.sv
// Bus condition detector.
// Turns the synchronized SCL/SDA levels into one-cycle events: SCL rise,
// SCL fall, start (SDA falls with SCL high) and stop (SDA rises with SCL
// high). Assumes the inputs are already synchronized and deglitched.
module sms_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_q,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, scl_p, sda_p;

    // Two-deep history of both lines; idle bus level is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            scl_p <= 1'b1;
            sda_q <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= scl_i;
            scl_p <= scl_q;
            sda_q <= sda_i;
            sda_p <= sda_q;
        end
    end

    // Edge and condition decode from the history.
    always_comb begin
        scl_rise = scl_q & ~scl_p;
        scl_fall = ~scl_q & scl_p;
        start_ev = scl_q & scl_p & sda_p & ~sda_q;
        stop_ev  = scl_q & scl_p & ~sda_p & sda_q;
    end
endmodule

// File: rtl/sms_addr_ctr.sv
// Word pointer.
// Holds the current location. It loads from the pointer byte, steps within
// a page during writes and steps across the whole array during reads.
// Assumes at most one command per cycle.
module sms_addr_ctr #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              inc_page,
    input  logic              inc_full,
    output logic [ADDR_W-1:0] addr
);
    localparam int HI_W = ADDR_W - PAGE_W;

    logic [PAGE_W-1:0] off_next;
    logic [HI_W-1:0]   page_hi;

    // Offset step that wraps inside the page.
    always_comb begin
        page_hi  = addr[ADDR_W-1:PAGE_W];
        off_next = addr[PAGE_W-1:0] + 1'b1;
    end

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)        addr <= '0;
        else if (load_en)  addr <= load_val;
        else if (inc_page) addr <= {page_hi, off_next};
        else if (inc_full) addr <= addr + 1'b1;
    end
endmodule

// File: rtl/sms_ctrl.sv
// Transaction sequencer.
// Shifts bytes in on SCL rises and decides acknowledges. It shifts read
// bytes out on SCL falls, issues loads and commits, and tracks the busy
// window. Assumes one event per cycle from the bus detector and a read port
// that answers in the same cycle.
module sms_ctrl
    import sms_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter logic [6:0] DEV_ADDR = SMS_DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_q,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              wp_i,
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [7:0]        rd_data,
    input  logic              commit_done,
    output logic              addr_load,
    output logic [ADDR_W-1:0] addr_load_val,
    output logic              inc_page,
    output logic              inc_full,
    output logic              sda_oe,
    output logic              ld_valid,
    output logic              ld_first,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [7:0]        ld_data,
    output logic              commit_req,
    output logic              busy
);
    sms_state_e  st;
    logic [3:0]  cnt;
    logic        full;
    logic [7:0]  shreg;
    logic [6:0]  txreg;
    logic        rw_q;
    logic        wp_lat;
    logic        first_pend;
    logic        pending;
    logic        mack;
    logic        dev_hit;

    // Address byte match, refused while a commit is running.
    always_comb dev_hit = (shreg[7:1] == DEV_ADDR) && !busy;

    // Main sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_IDLE;
            cnt           <= '0;
            full          <= 1'b0;
            shreg         <= '0;
            txreg         <= '0;
            rw_q          <= 1'b0;
            wp_lat        <= 1'b0;
            first_pend    <= 1'b0;
            pending       <= 1'b0;
            mack          <= 1'b0;
            busy          <= 1'b0;
            sda_oe        <= 1'b0;
            ld_valid      <= 1'b0;
            ld_first      <= 1'b0;
            ld_addr       <= '0;
            ld_data       <= '0;
            commit_req    <= 1'b0;
            addr_load     <= 1'b0;
            addr_load_val <= '0;
            inc_page      <= 1'b0;
            inc_full      <= 1'b0;
        end else begin
            ld_valid   <= 1'b0;
            commit_req <= 1'b0;
            addr_load  <= 1'b0;
            inc_page   <= 1'b0;
            inc_full   <= 1'b0;
            if (commit_done) busy <= 1'b0;

            if (stop_ev) begin
                st      <= ST_IDLE;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
                if (pending && !busy) begin
                    commit_req <= 1'b1;
                    busy       <= 1'b1;
                end
            end else if (start_ev) begin
                st      <= ST_DEV;
                cnt     <= '0;
                full    <= 1'b0;
                sda_oe  <= 1'b0;
                pending <= 1'b0;
            end else begin
                unique case (st)
                    ST_DEV, ST_WADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            shreg <= {shreg[6:0], sda_q};
                            cnt   <= cnt + 1'b1;
                            if (cnt == 4'd7) full <= 1'b1;
                        end else if (scl_fall && full) begin
                            full <= 1'b0;
                            cnt  <= '0;
                            if (st == ST_DEV) begin
                                if (dev_hit) begin
                                    rw_q   <= shreg[0];
                                    sda_oe <= 1'b1;
                                    st     <= ST_DEV_ACK;
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else if (st == ST_WADDR) begin
                                addr_load     <= 1'b1;
                                addr_load_val <= shreg[ADDR_W-1:0];
                                sda_oe        <= 1'b1;
                                st            <= ST_WADDR_ACK;
                            end else if (wp_lat) begin
                                st <= ST_SKIP;
                            end else begin
                                ld_valid   <= 1'b1;
                                ld_first   <= first_pend;
                                ld_addr    <= cur_addr;
                                ld_data    <= shreg;
                                first_pend <= 1'b0;
                                pending    <= 1'b1;
                                inc_page   <= 1'b1;
                                sda_oe     <= 1'b1;
                                st         <= ST_WDATA_ACK;
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            cnt <= '0;
                            if (rw_q) begin
                                txreg  <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                                st     <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                st     <= ST_WADDR;
                            end
                        end
                    end
                    ST_WADDR_ACK: begin
                        if (scl_fall) begin
                            sda_oe     <= 1'b0;
                            wp_lat     <= wp_i;
                            first_pend <= 1'b1;
                            st         <= ST_WDATA;
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            st     <= ST_WDATA;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (cnt == 4'd8) begin
                                sda_oe   <= 1'b0;
                                inc_full <= 1'b1;
                                st       <= ST_RD_ACK;
                            end else begin
                                sda_oe <= ~txreg[6];
                                txreg  <= {txreg[5:0], 1'b0};
                            end
                        end
                    end
                    ST_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_q;
                        end else if (scl_fall) begin
                            if (mack) begin
                                cnt    <= '0;
                                txreg  <= rd_data[6:0];
                                sda_oe <= ~rd_data[7];
                                st     <= ST_RD;
                            end else begin
                                st <= ST_SKIP;
                            end
                        end
                    end
                    ST_IDLE, ST_SKIP: begin
                        sda_oe <= 1'b0;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_mem_slave.sv
// Two-wire serial byte-memory slave, top level.
// Connects the bus condition detector, the sequencer and the word pointer.
// Assumes a companion block holds the array and the page staging buffer:
// it takes loads, performs a commit on request and answers reads from
// rd_addr in the same cycle.
module serial_mem_slave
    import sms_pkg::*;
#(
    parameter int         ADDR_W   = 8,
    parameter int         PAGE_W   = 4,
    parameter logic [6:0] DEV_ADDR = SMS_DEV_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    output logic              sda_oe,
    output logic              ld_valid,
    output logic              ld_first,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [7:0]        ld_data,
    output logic              commit_req,
    input  logic              commit_done,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data
);
    logic              sda_q, scl_rise, scl_fall, start_ev, stop_ev;
    logic              addr_load, inc_page, inc_full, busy;
    logic [ADDR_W-1:0] addr_load_val;
    logic [ADDR_W-1:0] cur_addr;

    sms_bus_events u_ev (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_q    (sda_q),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    sms_ctrl #(
        .ADDR_W   (ADDR_W),
        .DEV_ADDR (DEV_ADDR)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .sda_q         (sda_q),
        .scl_rise      (scl_rise),
        .scl_fall      (scl_fall),
        .start_ev      (start_ev),
        .stop_ev       (stop_ev),
        .wp_i          (wp_i),
        .cur_addr      (cur_addr),
        .rd_data       (rd_data),
        .commit_done   (commit_done),
        .addr_load     (addr_load),
        .addr_load_val (addr_load_val),
        .inc_page      (inc_page),
        .inc_full      (inc_full),
        .sda_oe        (sda_oe),
        .ld_valid      (ld_valid),
        .ld_first      (ld_first),
        .ld_addr       (ld_addr),
        .ld_data       (ld_data),
        .commit_req    (commit_req),
        .busy          (busy)
    );

    sms_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (addr_load),
        .load_val (addr_load_val),
        .inc_page (inc_page),
        .inc_full (inc_full),
        .addr     (cur_addr)
    );

    // Read port presents the live pointer.
    always_comb rd_addr = cur_addr;
endmodule

// File: rtl/sms_checker.sv
// Property checker for the serial byte-memory slave, bound to the top.
// Assumes the master changes SDA only while SCL is low, apart from start
// and stop conditions.
module sms_checker #(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scl_i,
    input logic              sda_oe,
    input logic              ld_valid,
    input logic              ld_first,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              commit_req,
    input logic              busy
);
    logic [ADDR_W-PAGE_W-1:0] last_pg;

    // Page of the most recent load, for the in-page check.
    always_ff @(posedge clk) begin
        if (!rst_n)        last_pg <= '0;
        else if (ld_valid) last_pg <= ld_addr[ADDR_W-1:PAGE_W];
    end

    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!sda_oe && !commit_req && !ld_valid));

    a_r10_drive_in_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_i);

    a_r4_no_load_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !ld_valid);

    a_r4_single_commit: assert property (@(posedge clk) disable iff (!rst_n)
        commit_req |=> (!commit_req && busy));

    a_r3_same_page: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_valid && !ld_first) |-> (ld_addr[ADDR_W-1:PAGE_W] == last_pg));
endmodule

bind serial_mem_slave sms_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe     (sda_oe),
    .ld_valid   (ld_valid),
    .ld_first   (ld_first),
    .ld_addr    (ld_addr),
    .commit_req (commit_req),
    .busy       (busy)
);

// File: tb/serial_mem_slave_tb.sv
// Bench: bit-level bus master, companion array model, reference image.
module serial_mem_slave_tb;
    localparam logic [7:0] DEVW = 8'hA0;
    localparam logic [7:0] DEVR = 8'hA1;
    localparam int COMMIT_CYC = 400;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_oe = 1'b0;
    logic       wp = 1'b0;
    logic       sda_oe, ld_valid, ld_first, commit_req;
    logic       commit_done = 1'b0;
    logic [7:0] ld_addr, ld_data, rd_addr, rd_data;
    wire        sda_line = !(m_oe || sda_oe);

    int checks = 0, errors = 0, commits = 0;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] stage [16];
    logic [15:0] sv = '0;
    logic [3:0]  stage_pg = '0;
    logic [7:0]  exp_addr = '0;
    logic [7:0]  wbuf [32];
    int          cd = 0;

    always #2 clk = ~clk;

    serial_mem_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .wp_i(wp),
        .sda_oe(sda_oe), .ld_valid(ld_valid), .ld_first(ld_first),
        .ld_addr(ld_addr), .ld_data(ld_data), .commit_req(commit_req),
        .commit_done(commit_done), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    assign rd_data = mem[rd_addr];

    // Companion model: staging buffer and delayed commit.
    always @(posedge clk) begin
        commit_done <= 1'b0;
        if (ld_valid) begin
            if (ld_first) sv = '0;
            stage[ld_addr[3:0]] = ld_data;
            sv[ld_addr[3:0]] = 1'b1;
            stage_pg = ld_addr[7:4];
        end
        if (commit_req) begin
            commits++;
            cd = COMMIT_CYC;
        end else if (cd > 0) begin
            cd--;
            if (cd == 0) begin
                for (int i = 0; i < 16; i++)
                    if (sv[i]) mem[{stage_pg, 4'(i)}] = stage[i];
                sv = '0;
                commit_done <= 1'b1;
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qwait(); repeat (3) @(negedge clk); endtask
    task automatic bus_start();
        m_oe = 0; qwait(); scl = 1; qwait(); m_oe = 1; qwait(); scl = 0; qwait();
    endtask
    task automatic bus_stop();
        m_oe = 1; qwait(); scl = 1; qwait(); m_oe = 0; qwait();
    endtask
    task automatic put_bit(input logic b);
        m_oe = !b; qwait(); scl = 1; qwait(); qwait(); scl = 0; qwait();
    endtask
    task automatic get_bit(output logic b);
        m_oe = 0; qwait(); scl = 1; qwait(); b = sda_line; qwait(); scl = 0; qwait();
    endtask
    task automatic put_byte(input logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = !b;
    endtask
    task automatic get_byte(input logic mack, output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(!mack);
    endtask

    // Poll with a bare write address until it is acknowledged.
    task automatic poll_ready(output int tries);
        logic a;
        tries = 0; a = 0;
        while (!a && tries < 50) begin
            bus_start(); put_byte(DEVW, a); bus_stop(); tries++;
        end
    endtask

    // Write session of n bytes from wbuf; updates the reference image.
    task automatic do_write(input logic [7:0] a, input int n, input logic wpv);
        logic ack; int tries;
        bus_start();
        put_byte(DEVW, ack); chk("R2 write address ack", ack, 1);
        wp = wpv;
        put_byte(a, ack); chk("R3 pointer byte ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], ack);
            chk(wpv ? "R5 protected data nack" : "R3 data ack", ack, !wpv);
        end
        bus_stop(); wp = 0;
        if (!wpv) begin
            for (int i = 0; i < n; i++) exp_mem[{a[7:4], a[3:0] + 4'(i)}] = wbuf[i];
            exp_addr = {a[7:4], a[3:0] + 4'(n)};
        end else exp_addr = a;
        if (!wpv && n > 0) begin
            poll_ready(tries);
            chk("R4 busy nack then ready", int'(tries > 1 && tries < 50), 1);
        end
    endtask

    task automatic read_bytes(input int n, input string req);
        logic [7:0] v;
        for (int i = 0; i < n; i++) begin
            get_byte(i != n - 1, v);
            chk(req, v, exp_mem[exp_addr]);
            exp_addr = exp_addr + 1'b1;
        end
        bus_stop();
    endtask

    task automatic read_at(input logic [7:0] a, input int n, input string req);
        logic ack;
        bus_start(); put_byte(DEVW, ack); chk("R7 address ack", ack, 1);
        put_byte(a, ack); chk("R7 pointer ack", ack, 1);
        bus_start(); put_byte(DEVR, ack); chk("R7 read address ack", ack, 1);
        exp_addr = a;
        read_bytes(n, req);
    endtask

    task automatic read_cur(input int n, input string req);
        logic ack;
        bus_start(); put_byte(DEVR, ack); chk("R6 read address ack", ack, 1);
        read_bytes(n, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic ack;
        int c0, n, r;
        logic [7:0] a;
        void'($urandom(32'd4242));
        for (int i = 0; i < 256; i++) begin mem[i] = 8'hFF; exp_mem[i] = 8'hFF; end
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 commit after reset", commit_req, 0);
        chk("R1 pointer after reset", rd_addr, 0);

        // R3/R4: single byte write, then random read back (R7)
        wbuf[0] = 8'h5A;
        do_write(8'h10, 1, 0);
        read_at(8'h10, 1, "R7 random read");

        // R3: page write of 18 bytes from offset 14 wraps in page
        for (int i = 0; i < 18; i++) wbuf[i] = 8'(8'h30 + i);
        do_write(8'h2E, 18, 0);
        read_at(8'h20, 16, "R3 page wrap content");

        // R6: current read after write continues after last loaded byte
        wbuf[0] = 8'hC1; wbuf[1] = 8'hC2; wbuf[2] = 8'hC3; wbuf[3] = 8'hC4;
        do_write(8'h7E, 4, 0);
        chk("R6 pointer after write", rd_addr, 8'h72);
        read_cur(1, "R6 current read");

        // R8: sequential read wraps 255 -> 0
        wbuf[0] = 8'hEE; wbuf[1] = 8'hEF;
        do_write(8'hFE, 2, 0);
        wbuf[0] = 8'h01;
        do_write(8'h00, 1, 0);
        read_at(8'hFE, 4, "R8 wrap read");

        // R2: wrong device address, later bytes ignored
        c0 = commits;
        bus_start(); put_byte(8'hA2, ack); chk("R2 wrong address nack", ack, 0);
        put_byte(8'h05, ack); chk("R2 ignored byte", ack, 0);
        put_byte(8'h77, ack); chk("R2 ignored byte", ack, 0);
        bus_stop();
        chk("R2 no commit after mismatch", commits, c0);
        read_at(8'h05, 1, "R2 content unchanged");

        // R5: write protect discards data
        c0 = commits;
        wbuf[0] = 8'h12; wbuf[1] = 8'h34;
        do_write(8'h30, 2, 1);
        repeat (20) @(negedge clk);
        chk("R5 no commit when protected", commits, c0);
        read_cur(1, "R5 content unchanged");

        // R9: start in mid data byte discards the session
        c0 = commits;
        bus_start(); put_byte(DEVW, ack); put_byte(8'h40, ack);
        put_byte(8'h99, ack); chk("R9 data ack", ack, 1);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_start(); put_byte(DEVR, ack); chk("R9 read after abort ack", ack, 1);
        exp_addr = 8'h41;
        read_bytes(1, "R9 pointer after abort");
        repeat (20) @(negedge clk);
        chk("R9 no commit after start abort", commits, c0);
        read_at(8'h40, 1, "R9 discarded byte");

        // R9: stop in mid byte commits complete bytes only
        bus_start(); put_byte(DEVW, ack); put_byte(8'h50, ack);
        put_byte(8'hA5, ack); put_byte(8'hB6, ack);
        for (int i = 0; i < 3; i++) put_bit(1'b1);
        bus_stop();
        exp_mem[8'h50] = 8'hA5; exp_mem[8'h51] = 8'hB6;
        poll_ready(n);
        chk("R9 partial stop committed", int'(n > 1 && n < 50), 1);
        read_at(8'h50, 3, "R9 complete bytes kept");

        // Seeded random mix of writes and reads
        for (int t = 0; t < 30; t++) begin
            r = int'($urandom % 3);
            a = 8'($urandom);
            if (r == 0) begin
                n = 1 + int'($urandom % 5);
                for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
                do_write(a, n, 0);
            end else if (r == 1) begin
                read_at(a, 1 + int'($urandom % 4), "R8 random sequential read");
            end else begin
                read_cur(1 + int'($urandom % 3), "R6 random current read");
            end
        end

        // R8: full array sweep with wrap
        read_at(8'h80, 256, "R8 full sweep");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule